// File: doc/BRIEF.md
# Bitmask Immediate OR Unit

This block expands a 13-bit logical-immediate code into a 64-bit constant. It then ORs that constant into every 64-bit lane of a vector operand and hands the result back as the new value of the same register. The code is not a literal value. It names an element width, a run of ones and a right-rotation. The block detects the width, builds the run, rotates it inside the element and replicates the element across 64 bits. Codes that name no legal width, and codes whose run would fill the whole element, are rejected.

The immediate can come from a raw 13-bit field, or it can be extracted from a full 32-bit instruction word. In the second case the fixed opcode bits are checked as well. The unit registers its results. A two-state controller tracks whether the output registers hold a fresh result. ST_IDLE means no result was captured on the last edge. ST_HOLD means a strobe was captured on the last edge. The transition ST_IDLE→ST_HOLD and the self-loop ST_HOLD→ST_HOLD are both taken on `in_valid`. The transition ST_HOLD→ST_IDLE and the self-loop ST_IDLE→ST_IDLE are both taken when `in_valid` is low.

Top module: `vec_orimm_unit`

## Requirements
- R1: With `use_insn`=1 the immediate is taken from `insn[17:5]` and `dst_reg` is `insn[4:0]`. With `use_insn`=0 the immediate is `imm_field` and `dst_reg` is 0.
- R2: Immediate bit 12 is the wide flag W, bits 11:6 are the rotation field and bits 5:0 are the length code. `size_code`=k means an element of 2^k bits. W=1 gives k=6. With W=0, a length code of 0xxxxx gives k=5, 10xxxx gives k=4, 110xxx gives k=3, 1110xx gives k=2 and 11110x gives k=1.
- R3: With W=0, length codes 111110 and 111111 are reserved. For these codes `invalid`=1, `size_code`=0 and `mask`=0.
- R4: For an element of E bits, the element holds (length code AND (E-1)) + 1 consecutive ones, starting at element bit 0 before rotation.
- R5: The element is rotated right by (rotation field AND (E-1)) positions within its E bits.
- R6: The rotated element is repeated to fill all 64 bits of `mask`, so `mask` is periodic with period E.
- R7: A length code whose low k bits are all ones, which would make the element all ones, sets `invalid`=1 and `mask`=0. `size_code` still reports k.
- R8: With `use_insn`=1, `insn[31:18]` must equal 14'b00000101000000. Any other value sets `invalid`=1 and `mask`=0.
- R9: When `invalid`=1, `vec_out` equals the captured `vec_in`, unchanged.
- R10: Every 64-bit lane of `vec_out` equals the same lane of the captured `vec_in` ORed with `mask`.
- R11: `out_valid` is high exactly in the cycle after a cycle with `in_valid`=1. Without a strobe, every output register keeps its value.
- R12: While reset is asserted, `out_valid`, `mask`, `size_code`, `invalid`, `dst_reg` and `vec_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe that captures a new operation |
| use_insn | input | 1 | 1: decode `insn`; 0: use `imm_field` |
| insn | input | 32 | Instruction word holding opcode, immediate and register number |
| imm_field | input | 13 | Raw logical-immediate code |
| vec_in | input | VL_W | Source vector operand |
| out_valid | output | 1 | Registered results are fresh |
| mask | output | 64 | Expanded constant (0 when invalid) |
| size_code | output | 3 | log2 of the element width, 0 when reserved |
| invalid | output | 1 | Reserved code, all-ones run or opcode mismatch |
| dst_reg | output | 5 | Destination register number |
| vec_out | output | VL_W | Lane-wise OR result |

## Verification
The assertions check several properties on every strobe. The expanded constant holds the right number of ones for its width and run length. It repeats with the detected element period. Both reserved codes are flagged. The lowest lane of the result equals the captured input ORed with the mask. The valid flag follows the strobe by one cycle, and outputs stay still without a strobe. The exact placement of the run after rotation, the width decoding for each of the 8192 codes, the opcode check and the field extraction from an instruction word are shown only by the bench. The bench compares every code against its own reference expansion and also runs directed instruction words.

// File: rtl/bmask_pkg.sv
package bmask_pkg;
    localparam int WORD_W = 64;
    localparam int IMM_W  = 13;
    localparam int FLD_W  = 6;
    localparam int LEN_W  = 3;
    localparam int REG_W  = 5;
    localparam int INSN_W = 32;
    localparam int OPC_LO = 18;
    localparam int OPC_W  = INSN_W - OPC_LO;
    localparam int NUM_SZ = $clog2(WORD_W);

    localparam logic [OPC_W-1:0] OPC_FIXED = 14'b00000101000000;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ctl_state_t;

    typedef struct packed {
        logic             wide;
        logic [FLD_W-1:0] rot;
        logic [FLD_W-1:0] len_code;
    } imm_fields_t;
endpackage

// File: rtl/bmask_size_detect.sv
module bmask_size_detect
    import bmask_pkg::*;
(
    input  logic             wide,
    input  logic [FLD_W-1:0] len_code,
    output logic [LEN_W-1:0] size_log2,
    output logic             reserved
);
    logic [FLD_W:0] probe;
    logic           found;

    assign probe = {wide, ~len_code};

    // Highest set bit of {wide, ~len_code}; ascending loop lets the top one win.
    always_comb begin
        size_log2 = '0;
        found     = 1'b0;
        for (int i = 0; i <= FLD_W; i++) begin
            if (probe[i]) begin
                size_log2 = LEN_W'(i);
                found     = 1'b1;
            end
        end
        reserved = !found || (size_log2 == '0);
    end
endmodule

// File: rtl/bmask_expand.sv
module bmask_expand
    import bmask_pkg::*;
(
    input  logic [LEN_W-1:0]  size_log2,
    input  logic [FLD_W-1:0]  len_code,
    input  logic [FLD_W-1:0]  rot,
    output logic [WORD_W-1:0] mask_raw,
    output logic              full_run
);
    localparam int NSLOT = 1 << LEN_W;

    logic [NSLOT-1:0][WORD_W-1:0] rep_arr;
    logic [FLD_W-1:0]             emask;

    assign rep_arr[0] = '0;
    assign rep_arr[NSLOT-1] = '0;

    for (genvar g = 1; g <= NUM_SZ; g++) begin : g_width
        localparam int EW = 1 << g;
        logic [EW-1:0] run_bits;
        logic [EW-1:0] rot_bits;
        logic [g-1:0]  s_lo;
        logic [g-1:0]  r_lo;

        assign s_lo = len_code[g-1:0];
        assign r_lo = rot[g-1:0];

        always_comb begin
            for (int i = 0; i < EW; i++) begin
                run_bits[i] = (i <= int'(s_lo));
            end
            rot_bits = (run_bits >> r_lo) | (run_bits << (EW - int'(r_lo)));
        end

        assign rep_arr[g] = {(WORD_W / EW){rot_bits}};
    end

    assign mask_raw = rep_arr[size_log2];
    assign emask    = FLD_W'((7'd1 << size_log2) - 7'd1);
    assign full_run = ((len_code & emask) == emask);
endmodule

// File: rtl/bmask_lane_or.sv
module bmask_lane_or
    import bmask_pkg::*;
#(
    parameter int VL_W = 256
) (
    input  logic [VL_W-1:0]   vec,
    input  logic [WORD_W-1:0] mask,
    output logic [VL_W-1:0]   res
);
    localparam int LANES = VL_W / WORD_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign res[l*WORD_W +: WORD_W] = vec[l*WORD_W +: WORD_W] | mask;
    end
endmodule

// File: rtl/vec_orimm_unit.sv
module vec_orimm_unit
    import bmask_pkg::*;
#(
    parameter int VL_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              use_insn,
    input  logic [31:0]       insn,
    input  logic [12:0]       imm_field,
    input  logic [VL_W-1:0]   vec_in,
    output logic              out_valid,
    output logic [63:0]       mask,
    output logic [2:0]        size_code,
    output logic              invalid,
    output logic [4:0]        dst_reg,
    output logic [VL_W-1:0]   vec_out
);
    ctl_state_t state_q, state_d;

    logic [IMM_W-1:0]  imm_sel;
    imm_fields_t       fld;
    logic [LEN_W-1:0]  det_len;
    logic              det_reserved;
    logic [WORD_W-1:0] mask_raw;
    logic              full_run;
    logic              opc_bad;
    logic              dec_invalid;
    logic [WORD_W-1:0] dec_mask;
    logic [LEN_W-1:0]  dec_size;
    logic [REG_W-1:0]  dec_reg;
    logic [VL_W-1:0]   vec_next;

    assign imm_sel     = use_insn ? insn[OPC_LO-1:REG_W] : imm_field;
    assign fld         = imm_sel;
    assign opc_bad     = use_insn && (insn[INSN_W-1:OPC_LO] != OPC_FIXED);
    assign dec_reg     = use_insn ? insn[REG_W-1:0] : '0;

    bmask_size_detect u_detect (
        .wide      (fld.wide),
        .len_code  (fld.len_code),
        .size_log2 (det_len),
        .reserved  (det_reserved)
    );

    bmask_expand u_expand (
        .size_log2 (det_len),
        .len_code  (fld.len_code),
        .rot       (fld.rot),
        .mask_raw  (mask_raw),
        .full_run  (full_run)
    );

    assign dec_invalid = det_reserved | full_run | opc_bad;
    assign dec_mask    = dec_invalid ? '0 : mask_raw;
    assign dec_size    = det_reserved ? '0 : det_len;

    bmask_lane_or #(.VL_W(VL_W)) u_lanes (
        .vec  (vec_in),
        .mask (dec_mask),
        .res  (vec_next)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask      <= '0;
            size_code <= '0;
            invalid   <= 1'b0;
            dst_reg   <= '0;
            vec_out   <= '0;
        end else if (in_valid) begin
            mask      <= dec_mask;
            size_code <= dec_size;
            invalid   <= dec_invalid;
            dst_reg   <= dec_reg;
            vec_out   <= vec_next;
        end
    end

    assign out_valid = (state_q == ST_HOLD);

    // Checker helpers
    logic [WORD_W-1:0] chk_rot;
    logic [FLD_W-1:0]  chk_s;
    int                chk_ones;

    assign chk_rot  = WORD_W'({dec_mask, dec_mask} >> (7'd1 << det_len));
    assign chk_s    = fld.len_code & FLD_W'((7'd1 << det_len) - 7'd1);
    assign chk_ones = (WORD_W >> det_len) * (int'(chk_s) + 1);

    p_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !dec_invalid |-> $countones(dec_mask) == chk_ones);

    p_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !dec_invalid |-> chk_rot == dec_mask);

    p_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !fld.wide && (fld.len_code[5:1] == 5'b11111) |-> det_reserved);

    p_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> vec_out[WORD_W-1:0] == ($past(vec_in[WORD_W-1:0]) | mask));

    p_invalid_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> mask == '0);

    p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(mask) && $stable(vec_out));
endmodule

// File: tb/vec_orimm_unit_test.sv
`timescale 1ns/1ps
module vec_orimm_unit_test;
    localparam int VL = 256;
    localparam int NL = VL / 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          use_insn = 1'b0;
    logic [31:0]   insn = '0;
    logic [12:0]   imm_field = '0;
    logic [VL-1:0] vec_in = '0;
    logic          out_valid;
    logic [63:0]   mask;
    logic [2:0]    size_code;
    logic          invalid;
    logic [4:0]    dst_reg;
    logic [VL-1:0] vec_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vec_orimm_unit #(.VL_W(VL)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_insn(use_insn),
        .insn(insn), .imm_field(imm_field), .vec_in(vec_in),
        .out_valid(out_valid), .mask(mask), .size_code(size_code),
        .invalid(invalid), .dst_reg(dst_reg), .vec_out(vec_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference expansion: scans for the width, then places each bit by position.
    function automatic void ref_dec(input logic [12:0] imm, output logic [63:0] m,
                                    output logic [2:0] sz, output logic inv,
                                    output logic resv);
        int k, e, s, r;
        k = 0;
        if (imm[12]) k = 6;
        else begin
            for (int b = 5; b >= 1; b--) begin
                if (k == 0 && imm[b] == 1'b0) k = b;
            end
        end
        m = '0;
        resv = (k == 0);
        sz = resv ? 3'd0 : 3'(k);
        inv = resv;
        if (!resv) begin
            e = 1 << k;
            s = int'(imm[5:0]) % e;
            r = int'(imm[11:6]) % e;
            if (s == e - 1) inv = 1'b1;
            else begin
                for (int j = 0; j < 64; j++) begin
                    m[j] = (((j % e) + r) % e) <= s;
                end
            end
        end
    endfunction

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VL-1:0] or_lanes(input logic [VL-1:0] v, input logic [63:0] m);
        logic [VL-1:0] o;
        for (int l = 0; l < NL; l++) o[l*64 +: 64] = v[l*64 +: 64] | m;
        return o;
    endfunction

    task automatic check_out(input logic [12:0] imm, input logic [VL-1:0] v,
                             input logic opc_bad, input logic [4:0] reg_exp);
        logic [63:0] m;
        logic [2:0]  sz;
        logic        inv, resv;
        ref_dec(imm, m, sz, inv, resv);
        if (opc_bad) begin
            inv = 1'b1;
            m = '0;
        end
        chk(out_valid == 1'b1, "R11", "out_valid after strobe", VL'(out_valid), VL'(1));
        chk(mask == m, resv ? "R3" : "R4", "mask", VL'(mask), VL'(m));
        chk(size_code == sz, "R2", "size_code", VL'(size_code), VL'(sz));
        chk(invalid == inv, opc_bad ? "R8" : (resv ? "R3" : "R7"), "invalid",
            VL'(invalid), VL'(inv));
        chk(vec_out == or_lanes(v, m), inv ? "R9" : "R10", "vec_out", vec_out, or_lanes(v, m));
        chk(dst_reg == reg_exp, "R1", "dst_reg", VL'(dst_reg), VL'(reg_exp));
    endtask

    task automatic one_raw(input logic [12:0] imm, input string req, input logic [63:0] exp_m);
        logic [VL-1:0] v;
        v = rand_vec();
        @(negedge clk);
        use_insn = 1'b0; imm_field = imm; vec_in = v; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(mask == exp_m, req, "directed mask", VL'(mask), VL'(exp_m));
        check_out(imm, v, 1'b0, 5'd0);
    endtask

    task automatic one_insn(input logic [31:0] w, input logic [12:0] decoy);
        logic [VL-1:0] v;
        v = rand_vec();
        @(negedge clk);
        use_insn = 1'b1; insn = w; imm_field = decoy; vec_in = v; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_out(w[17:5], v, w[31:18] != 14'b00000101000000, w[4:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [12:0]   prev_imm;
        logic [VL-1:0] prev_vec;
        logic [63:0]   held_m;
        logic [VL-1:0] held_v;
        void'($urandom(32'd2718));

        // R12: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && mask == '0 && size_code == '0 && invalid == 1'b0 &&
            dst_reg == '0 && vec_out == '0, "R12", "reset outputs",
            {out_valid, invalid, size_code, dst_reg, mask}, '0);
        rst_n = 1'b1;

        // Directed corners
        one_raw({1'b1, 6'd0, 6'd3}, "R4", 64'h0000_0000_0000_000F);
        one_raw({1'b1, 6'd4, 6'd0}, "R5", 64'h1000_0000_0000_0000);
        one_raw({1'b0, 6'd0, 6'b111100}, "R6", 64'h5555_5555_5555_5555);
        one_raw({1'b0, 6'd1, 6'b110000}, "R5", 64'h8080_8080_8080_8080);
        one_raw({1'b0, 6'd0, 6'b111110}, "R3", 64'h0);
        one_raw({1'b0, 6'd0, 6'b111111}, "R3", 64'h0);
        one_raw({1'b0, 6'd5, 6'b011111}, "R7", 64'h0);
        one_raw({1'b1, 6'd9, 6'b111111}, "R7", 64'h0);

        // Every code, back to back (R2..R7, R10, R11)
        prev_imm = '0;
        prev_vec = '0;
        for (int k = 0; k < 8192; k++) begin
            @(negedge clk);
            if (k > 0) check_out(prev_imm, prev_vec, 1'b0, 5'd0);
            prev_imm = 13'(k);
            prev_vec = rand_vec();
            use_insn = 1'b0; imm_field = prev_imm; vec_in = prev_vec; in_valid = 1'b1;
        end
        @(negedge clk);
        check_out(prev_imm, prev_vec, 1'b0, 5'd0);
        in_valid = 1'b0;

        // R11: no strobe leaves outputs untouched
        held_m = mask;
        held_v = vec_out;
        imm_field = 13'h1ABC;
        vec_in = rand_vec();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid idle", VL'(out_valid), VL'(0));
        chk(mask == held_m, "R11", "mask held", VL'(mask), VL'(held_m));
        chk(vec_out == held_v, "R11", "vec_out held", vec_out, held_v);

        // R1 / R8 / R9: instruction-word path, with random fields
        for (int t = 0; t < 40; t++) begin
            logic [12:0] im;
            logic [4:0]  rg;
            im = 13'($urandom);
            rg = 5'($urandom);
            one_insn({14'b00000101000000, im, rg}, ~im);
        end
        one_insn({14'b00000101000000, 13'b1_000000_000111, 5'd17}, 13'h0);
        one_insn({14'b10000101000000, 13'b1_000000_000111, 5'd3}, 13'b1_000000_000111);
        one_insn({14'b00000101000001, 13'b0_000010_001111, 5'd31}, 13'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule